// File: doc/BRIEF.md
# Nested Interrupt Controller

This block arbitrates interrupt requests for a processor core. It watches a set of hardware request lines and a set of software-exception strobes, and keeps one pending bit and one enable bit per source. Each cycle it finds the most urgent source that is both pending and enabled. If the current service state allows that source to enter, the block reports it to the core with the handler address held in that source's vector register. It also tells the core whether to throw away the instructions already in flight (software exceptions) or to let them finish first (hardware interrupts).

Sources are numbered with exceptions first and hardware lines after them, and a lower number always wins. Accepted sources go onto a small in-service stack. A return-from-interrupt strobe pops that stack. A control input chooses between nested service, where only a more urgent source may preempt, and non-nested service, where nothing is accepted until the handler returns. Four of the hardware lines can be set to edge or level sensing at run time. The rest have their sensing fixed by a parameter. Software can read the pending bits and can write them, which lets it raise or cancel edge-type requests.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, every pending bit is 0, every enable bit is 1 (enabled), the in-service stack is empty, `take_valid` is 0, and each vector register holds its source number times 16.
- R2: An edge-sensed source sets its pending bit on a 0-to-1 transition of its line and keeps it set after the line falls, until the source is accepted. An exception source sets its pending bit in every cycle its strobe is high. Acceptance clears the bit, unless a new event arrives in the same cycle.
- R3: A level-sensed source's pending bit equals its line as sampled at the previous clock edge. Software writes to that bit have no effect.
- R4: Hardware lines 0 to 3 use edge sensing when bit j of the mode register is 1 and level sensing when it is 0, and the mode register resets to 0. Lines 4 and above take their sensing from bit j of the `FIXED_EDGE` parameter.
- R5: A `latch_we` write replaces the pending bits of exception and edge-sensed sources with `latch_wdata`. An event in the same cycle still sets its bit.
- R6: Source s maps to exception strobe s for s < N_EXC and to hardware line s-N_EXC otherwise. Among the sources that are both pending and enabled, the lowest number is chosen. A disabled source is never accepted.
- R7: An acceptance gives a one-cycle `take_valid` pulse, one clock edge after the pending bit becomes visible on `latch_q`. In the same cycle `take_src` holds the source number, `take_vector` holds its vector register, `svc_active` is 1 and `svc_src` equals `take_src`.
- R8: `take_abort` is 1 on an acceptance exactly when the accepted source is an exception (number < N_EXC).
- R9: With `nest_en` = 1 and a source in service, only a source with a lower number than `svc_src` may be accepted, and it then becomes `svc_src`.
- R10: With `nest_en` = 0, no source is accepted while `svc_active` is 1.
- R11: A `rti` pulse pops the in-service stack and exposes the previous entry. No source is accepted at the clock edge where `rti` is sampled high. No source is accepted while the stack holds DEPTH entries.
- R12: A `vec_we` write stores `vec_wdata` into the vector register of source `vec_idx`, and later acceptances of that source report the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_irq | input | N_HW | Hardware request lines |
| exc_req | input | N_EXC | Software-exception strobes |
| nest_en | input | 1 | 1 = nested service, 0 = non-nested |
| rti | input | 1 | Return-from-interrupt strobe |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | NSRC | New enable bits (1 = enabled) |
| latch_we | input | 1 | Write strobe for the pending register |
| latch_wdata | input | NSRC | New pending bits |
| mode_we | input | 1 | Write strobe for the sensing mode of lines 0..3 |
| mode_wdata | input | 4 | New mode bits (1 = edge, 0 = level) |
| vec_we | input | 1 | Write strobe for a vector register |
| vec_idx | input | IDX_W | Source number of the vector to write |
| vec_wdata | input | VEC_W | New vector value |
| latch_q | output | NSRC | Pending bits |
| en_q | output | NSRC | Enable bits |
| take_valid | output | 1 | Acceptance pulse |
| take_src | output | IDX_W | Accepted source number |
| take_vector | output | VEC_W | Handler vector of the accepted source |
| take_abort | output | 1 | 1 = discard in-flight instructions, 0 = let them drain |
| svc_active | output | 1 | In-service stack is not empty |
| svc_src | output | IDX_W | Source on top of the in-service stack |

## Verification
Line events, exception strobes and register writes show up on `latch_q` and `en_q` one clock edge after they are sampled. The acceptance they cause (`take_valid`, `take_src`, `take_vector`, `take_abort`, and the updated `svc_src`) appears one edge after that. A `rti` changes `svc_src` one edge after it is sampled and blocks any acceptance at that same edge. The bench changes inputs and reads outputs 1 ns after a rising edge. Each check is placed after the exact number of edges given above, so every sample sees settled registered outputs. It sweeps every single source and every ordered pair of edge-capable sources, in both nested and non-nested modes, and computes the winner and the vector arithmetically.

// File: rtl/nic_pkg.sv
// Package: shared constants and helpers for the nested interrupt controller.
// Assumes source numbering places exceptions below hardware lines.
package nic_pkg;
    // Number of hardware lines whose sensing is programmable at run time
    localparam int EXT_LINES = 4;

    // Reset value of a vector register: source number times 16
    function automatic logic [31:0] vec_reset(input int idx);
        return 32'(idx) << 4;
    endfunction
endpackage

// File: rtl/nic_latch.sv
// Module: pending-bit register with per-source edge or level capture.
// Assumes exceptions occupy the low source numbers and hardware lines follow.
// Edge sources hold until cleared by acceptance; level sources shadow the line.
module nic_latch #(
    parameter int N_EXC = 2,
    parameter int N_HW = 8,
    parameter logic [N_HW-1:0] FIXED_EDGE = '0,
    localparam int NSRC = N_EXC + N_HW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_HW-1:0] hw_irq,
    input  logic [N_EXC-1:0] exc_req,
    input  logic [nic_pkg::EXT_LINES-1:0] mode_q,
    input  logic            latch_we,
    input  logic [NSRC-1:0] latch_wdata,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] latch_q
);
    logic [N_HW-1:0] hw_prev;
    logic [NSRC-1:0] nxt;

    // Remember last sampled line values for rising-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) hw_prev <= '0;
        else        hw_prev <= hw_irq;
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        logic base;
        // Held value after software write and acceptance clear
        assign base = (latch_we ? latch_wdata[s] : latch_q[s]) & ~clr[s];
        if (s < N_EXC) begin : g_exc
            assign nxt[s] = base | exc_req[s];
        end else begin : g_hw
            localparam int L = s - N_EXC;
            logic edge_sel;
            if (L < nic_pkg::EXT_LINES) begin : g_prog
                assign edge_sel = mode_q[L];
            end else begin : g_fix
                assign edge_sel = FIXED_EDGE[L];
            end
            assign nxt[s] = edge_sel ? (base | (hw_irq[L] & ~hw_prev[L]))
                                     : hw_irq[L];
        end
    end

    // Pending register update
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= nxt;
    end
endmodule

// File: rtl/nic_stack.sv
// Module: in-service stack of accepted source numbers.
// Assumes push and pop are never requested together and push never when full.
module nic_stack #(
    parameter int DEPTH = 4,
    parameter int IDX_W = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [IDX_W-1:0] push_idx,
    input  logic             pop,
    output logic [IDX_W-1:0] top,
    output logic             empty,
    output logic             full
);
    logic [IDX_W-1:0] stk [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic [SP_W-1:0]  wr_ptr;
    logic [SP_W-1:0]  rd_ptr;

    assign wr_ptr = cnt[SP_W-1:0];
    assign rd_ptr = wr_ptr - 1'b1;
    assign empty  = (cnt == '0);
    assign full   = (cnt == CNT_W'(DEPTH));
    assign top    = empty ? '0 : stk[rd_ptr];

    // Occupancy count: pop when non-empty, push otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (pop && !empty)  cnt <= cnt - 1'b1;
        else if (push && !full)  cnt <= cnt + 1'b1;
    end

    // Entry storage written at the current fill level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
        end else if (push && !full && !pop) begin
            stk[wr_ptr] <= push_idx;
        end
    end
endmodule

// File: rtl/nic_arbiter.sv
// Module: fixed-priority selection and admission control.
// Assumes a lower source number is more urgent; purely combinational.
module nic_arbiter #(
    parameter int NSRC = 10,
    parameter int IDX_W = 4
) (
    input  logic [NSRC-1:0]  latch_q,
    input  logic [NSRC-1:0]  en_q,
    input  logic [IDX_W-1:0] top,
    input  logic             empty,
    input  logic             full,
    input  logic             nest_en,
    input  logic             rti,
    output logic             grant,
    output logic [IDX_W-1:0] win
);
    logic [NSRC-1:0] pend;
    logic            found;
    logic            allow;

    assign pend = latch_q & en_q;

    // Lowest-numbered pending enabled source
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                found = 1'b1;
                win   = IDX_W'(i);
            end
        end
    end

    // Admission: stack space, no return this cycle, nesting rule
    assign allow = !full && !rti && (empty || (nest_en && (win < top)));
    assign grant = found && allow;
endmodule

// File: rtl/nest_irq_ctrl.sv
// Module: top of the nested interrupt controller.
// Holds enable, mode and vector registers, registers the acceptance outputs,
// and ties together capture, arbitration and the in-service stack.
// Assumes synchronous active-low reset and a single clock.
module nest_irq_ctrl #(
    parameter int N_EXC = 2,
    parameter int N_HW = 8,
    parameter int DEPTH = 4,
    parameter int VEC_W = 16,
    parameter logic [N_HW-1:0] FIXED_EDGE = 8'b0011_0000,
    localparam int NSRC = N_EXC + N_HW,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_HW-1:0]  hw_irq,
    input  logic [N_EXC-1:0] exc_req,
    input  logic             nest_en,
    input  logic             rti,
    input  logic             en_we,
    input  logic [NSRC-1:0]  en_wdata,
    input  logic             latch_we,
    input  logic [NSRC-1:0]  latch_wdata,
    input  logic             mode_we,
    input  logic [3:0]       mode_wdata,
    input  logic             vec_we,
    input  logic [IDX_W-1:0] vec_idx,
    input  logic [VEC_W-1:0] vec_wdata,
    output logic [NSRC-1:0]  latch_q,
    output logic [NSRC-1:0]  en_q,
    output logic             take_valid,
    output logic [IDX_W-1:0] take_src,
    output logic [VEC_W-1:0] take_vector,
    output logic             take_abort,
    output logic             svc_active,
    output logic [IDX_W-1:0] svc_src
);
    logic [nic_pkg::EXT_LINES-1:0] mode_q;
    logic [VEC_W-1:0] vec_q [NSRC];
    logic             grant;
    logic [IDX_W-1:0] win;
    logic [NSRC-1:0]  clr;
    logic [IDX_W-1:0] top;
    logic             empty;
    logic             full;

    assign clr        = grant ? (NSRC'(1) << win) : '0;
    assign svc_active = !empty;
    assign svc_src    = top;

    // Enable register, all sources enabled at reset
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '1;
        else if (en_we) en_q <= en_wdata;
    end

    // Sensing mode of the programmable lines, level at reset
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (mode_we) mode_q <= mode_wdata;
    end

    // Vector registers, reset to source number times 16
    always_ff @(posedge clk) begin
        for (int i = 0; i < NSRC; i++) begin
            if (!rst_n)
                vec_q[i] <= VEC_W'(nic_pkg::vec_reset(i));
            else if (vec_we && vec_idx == IDX_W'(i))
                vec_q[i] <= vec_wdata;
        end
    end

    // Registered acceptance report toward the core
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_valid  <= 1'b0;
            take_src    <= '0;
            take_vector <= '0;
            take_abort  <= 1'b0;
        end else begin
            take_valid <= grant;
            if (grant) begin
                take_src    <= win;
                take_vector <= vec_q[win];
                take_abort  <= (win < IDX_W'(N_EXC));
            end
        end
    end

    nic_latch #(.N_EXC(N_EXC), .N_HW(N_HW), .FIXED_EDGE(FIXED_EDGE)) u_latch (
        .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .exc_req(exc_req),
        .mode_q(mode_q), .latch_we(latch_we), .latch_wdata(latch_wdata),
        .clr(clr), .latch_q(latch_q)
    );

    nic_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
        .latch_q(latch_q), .en_q(en_q), .top(top), .empty(empty), .full(full),
        .nest_en(nest_en), .rti(rti), .grant(grant), .win(win)
    );

    nic_stack #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(grant), .push_idx(win), .pop(rti),
        .top(top), .empty(empty), .full(full)
    );
endmodule

// Checker: temporal properties of the controller's acceptance behaviour.
// Keeps one-cycle copies of inputs and state to relate a report to its cause.
module nest_irq_ctrl_chk #(
    parameter int N_EXC = 2,
    parameter int N_HW = 8,
    localparam int NSRC = N_EXC + N_HW,
    localparam int IDX_W = $clog2(NSRC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             nest_en,
    input logic             rti,
    input logic [NSRC-1:0]  en_q,
    input logic             take_valid,
    input logic [IDX_W-1:0] take_src,
    input logic             take_abort,
    input logic             svc_active,
    input logic [IDX_W-1:0] svc_src
);
    logic             act_d;
    logic [IDX_W-1:0] src_d;
    logic             nest_d;
    logic             rti_d;
    logic [NSRC-1:0]  en_d;

    // Previous-cycle view of state that governed the latest decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_d  <= 1'b0;
            src_d  <= '0;
            nest_d <= 1'b0;
            rti_d  <= 1'b0;
            en_d   <= '0;
        end else begin
            act_d  <= svc_active;
            src_d  <= svc_src;
            nest_d <= nest_en;
            rti_d  <= rti;
            en_d   <= en_q;
        end
    end

    // R8
    abort_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_valid |-> (take_abort == (take_src < IDX_W'(N_EXC))));

    // R9
    nest_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_valid && act_d && nest_d) |-> (take_src < src_d));

    // R10
    no_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_valid && act_d) |-> nest_d);

    // R6
    enabled_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_valid |-> en_d[take_src]);

    // R11
    rti_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rti_d |-> !take_valid);

    // R7
    svc_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_valid |-> (svc_active && svc_src == take_src));
endmodule

bind nest_irq_ctrl nest_irq_ctrl_chk #(.N_EXC(N_EXC), .N_HW(N_HW)) u_chk (
    .clk(clk), .rst_n(rst_n), .nest_en(nest_en), .rti(rti), .en_q(en_q),
    .take_valid(take_valid), .take_src(take_src), .take_abort(take_abort),
    .svc_active(svc_active), .svc_src(svc_src)
);

// File: tb/nest_irq_ctrl_test.sv
// Bench: sweeps single sources and source pairs on the default configuration.
module nest_irq_ctrl_test;
    localparam int N_EXC = 2;
    localparam int N_HW = 8;
    localparam int NSRC = 10;
    localparam int IDX_W = 4;
    localparam int VEC_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_HW-1:0]  hw_irq = '0;
    logic [N_EXC-1:0] exc_req = '0;
    logic             nest_en = 1'b0;
    logic             rti = 1'b0;
    logic             en_we = 1'b0;
    logic [NSRC-1:0]  en_wdata = '0;
    logic             latch_we = 1'b0;
    logic [NSRC-1:0]  latch_wdata = '0;
    logic             mode_we = 1'b0;
    logic [3:0]       mode_wdata = '0;
    logic             vec_we = 1'b0;
    logic [IDX_W-1:0] vec_idx = '0;
    logic [VEC_W-1:0] vec_wdata = '0;
    logic [NSRC-1:0]  latch_q;
    logic [NSRC-1:0]  en_q;
    logic             take_valid;
    logic [IDX_W-1:0] take_src;
    logic [VEC_W-1:0] take_vector;
    logic             take_abort;
    logic             svc_active;
    logic [IDX_W-1:0] svc_src;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nest_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .exc_req(exc_req),
        .nest_en(nest_en), .rti(rti), .en_we(en_we), .en_wdata(en_wdata),
        .latch_we(latch_we), .latch_wdata(latch_wdata), .mode_we(mode_we),
        .mode_wdata(mode_wdata), .vec_we(vec_we), .vec_idx(vec_idx),
        .vec_wdata(vec_wdata), .latch_q(latch_q), .en_q(en_q),
        .take_valid(take_valid), .take_src(take_src), .take_vector(take_vector),
        .take_abort(take_abort), .svc_active(svc_active), .svc_src(svc_src)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Software-raise pending bits; they appear after this edge
    task automatic raise(input logic [NSRC-1:0] bits);
        latch_we = 1'b1;
        latch_wdata = latch_q | bits;
        step();
        latch_we = 1'b0;
    endtask

    task automatic do_rti();
        rti = 1'b1;
        step();
        rti = 1'b0;
    endtask

    // Check an acceptance of source s with expected vector v
    task automatic expect_take(input string req, input int s, input int v);
        chk({req, " take_valid"}, int'(take_valid), 1);
        chk({req, " take_src"}, int'(take_src), s);
        chk({req, " take_vector"}, int'(take_vector), v);
        chk({"R8 ", req, " take_abort"}, int'(take_abort), (s < N_EXC) ? 1 : 0);
        chk({"R7 ", req, " svc_src"}, int'(svc_src), s);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 latch_q", int'(latch_q), 0);
        chk("R1 en_q", int'(en_q), 1023);
        chk("R1 take_valid", int'(take_valid), 0);
        chk("R1 svc_active", int'(svc_active), 0);

        // R4 lines 0..3 to edge sensing (mode bit 1 = edge)
        mode_we = 1'b1; mode_wdata = 4'hF; step(); mode_we = 1'b0;

        // R6 R7 R8 R5 every edge-capable source alone (sources 0..7)
        for (int i = 0; i < 8; i++) begin
            raise(NSRC'(1) << i);
            step();
            expect_take("R7 single", i, i * 16);
            chk("R2 cleared on take", int'(latch_q[i]), 0);
            do_rti();
            chk("R11 pop empties", int'(svc_active), 0);
        end

        // R6 R10 R11 every pair, non-nested
        nest_en = 1'b0;
        for (int a = 0; a < 8; a++) begin
            for (int b = a + 1; b < 8; b++) begin
                raise((NSRC'(1) << a) | (NSRC'(1) << b));
                step();
                chk("R6 pair winner", int'(take_src), a);
                step();
                chk("R10 no take in service", int'(take_valid), 0);
                do_rti();
                chk("R11 no take at rti edge", int'(take_valid), 0);
                step();
                chk("R6 pair second", int'(take_src), b);
                chk("R6 pair second valid", int'(take_valid), 1);
                do_rti();
            end
        end

        // R9 every pair, nested: more urgent source preempts
        nest_en = 1'b1;
        for (int a = 0; a < 8; a++) begin
            for (int b = a + 1; b < 8; b++) begin
                raise(NSRC'(1) << b);
                step();
                chk("R9 first", int'(take_src), b);
                raise(NSRC'(1) << a);
                step();
                chk("R9 preempt valid", int'(take_valid), 1);
                chk("R9 preempt svc_src", int'(svc_src), a);
                do_rti();
                chk("R9 back to outer", int'(svc_src), b);
                do_rti();
                chk("R9 empty", int'(svc_active), 0);
            end
        end

        // R9 less urgent source waits while nested
        raise(NSRC'(1) << 3);
        step();
        raise(NSRC'(1) << 5);
        step();
        chk("R9 lower blocked", int'(take_valid), 0);
        do_rti();
        step();
        chk("R9 lower after return", int'(take_src), 5);
        do_rti();

        // R11 full stack blocks acceptance
        for (int k = 7; k >= 4; k--) begin
            raise(NSRC'(1) << k);
            step();
            chk("R11 fill", int'(take_src), k);
        end
        raise(NSRC'(1) << 3);
        step();
        chk("R11 full blocks", int'(take_valid), 0);
        chk("R11 still pending", int'(latch_q[3]), 1);
        do_rti();
        chk("R11 pop exposes", int'(svc_src), 5);
        step();
        chk("R11 taken after pop", int'(take_src), 3);
        repeat (4) do_rti();
        chk("R11 drained", int'(svc_active), 0);

        // R3 level source 8 (line 6, FIXED_EDGE bit 6 = 0)
        hw_irq[6] = 1'b1;
        step();
        chk("R3 level follows", int'(latch_q[8]), 1);
        step();
        expect_take("R3 level", 8, 128);
        do_rti();
        step();
        chk("R3 level retaken", int'(take_valid), 1);
        hw_irq[6] = 1'b0;
        do_rti();
        chk("R3 level dropped", int'(latch_q[8]), 0);
        raise(NSRC'(1) << 8);
        chk("R3 write ignored", int'(latch_q[8]), 0);
        step();
        chk("R3 no take", int'(take_valid), 0);

        // R2 R6 edge hold on line 0 (source 2) while disabled
        en_we = 1'b1; en_wdata = 10'h3FB; step(); en_we = 1'b0;
        hw_irq[0] = 1'b1; step(); hw_irq[0] = 1'b0; step();
        chk("R2 edge held", int'(latch_q[2]), 1);
        step();
        chk("R6 disabled not taken", int'(take_valid), 0);
        en_we = 1'b1; en_wdata = '1; step(); en_we = 1'b0;
        step();
        expect_take("R2 edge", 2, 32);
        do_rti();

        // R4 line 0 in level mode
        mode_we = 1'b1; mode_wdata = 4'hE; step(); mode_we = 1'b0;
        en_we = 1'b1; en_wdata = 10'h3FB; step(); en_we = 1'b0;
        hw_irq[0] = 1'b1; step();
        chk("R4 level mode set", int'(latch_q[2]), 1);
        hw_irq[0] = 1'b0; step();
        chk("R4 level mode clear", int'(latch_q[2]), 0);
        en_we = 1'b1; en_wdata = '1; step(); en_we = 1'b0;
        mode_we = 1'b1; mode_wdata = 4'hF; step(); mode_we = 1'b0;

        // R2 R8 exception strobe
        exc_req[1] = 1'b1; step(); exc_req[1] = 1'b0;
        chk("R2 exception latched", int'(latch_q[1]), 1);
        step();
        expect_take("R8 exception", 1, 16);
        do_rti();

        // R12 vector write
        vec_we = 1'b1; vec_idx = 4'd3; vec_wdata = 16'hBEEF; step(); vec_we = 1'b0;
        raise(NSRC'(1) << 3);
        step();
        expect_take("R12 vector", 3, 16'hBEEF);
        do_rti();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule